// File: doc/BRIEF.md
# Cache Refill Arbiter

This block lets an instruction cache and a data cache share one port into the next memory level, which may be an L2 cache or RAM. Each cache raises its request line with a word address when it misses. The arbiter serves one refill at a time. The granted cache sees its grant line go high. The arbiter then issues a single-word read to memory and waits for memory to return the data, however long that takes. It passes the word back to the granted cache with a one-cycle done pulse.

The controller is a five-state machine: idle, two fetch states and two finish states. The data cache always wins when both caches are waiting. Every transfer passes through a fetch phase and then a finish phase. After the finish phase the controller always goes back to idle before it makes the next decision. When idle, it drives nothing onto the memory port.

Back-pressure rules:
- Memory side: `mem_req` acts as the valid of the read transaction. `mem_req` and `mem_addr` hold steady until memory raises `mem_rvalid`, so memory stalls the arbiter simply by delaying `mem_rvalid`. Memory may answer in the first cycle of the request.
- Cache side: a cache keeps its request high until its done pulse. A request that is still high in the cycle after the done pulse counts as a new request.

Top module: `refill_arb`

## Requirements
- R1: While `rst` is high and in the cycle after it, both grants, both done pulses and `mem_req` are low, whatever the request inputs do.
- R2: When the controller is idle and `dc_req` is high, the next cycle has `dc_grant` and `mem_req` high, with `mem_addr` equal to `dc_addr`. This holds whether or not `ic_req` is high.
- R3: When idle, the instruction cache is granted on the next cycle only if `ic_req` is high and `dc_req` is low. `mem_addr` then equals `ic_addr`.
- R4: During a fetch, `mem_req` stays high and `mem_addr` stays unchanged until the first cycle in which `mem_rvalid` is high. That cycle may be the first fetch cycle.
- R5: In the cycle after `mem_rvalid`, the granted cache gets a done pulse lasting exactly one cycle, and its data output equals the `mem_rdata` value that was returned. The other cache's done stays low.
- R6: A finish cycle is always followed by an idle cycle with `mem_req` and both grants low. When no request is present, `mem_req` stays low.
- R7: At most one grant is high in any cycle. A grant stays high from its first fetch cycle through its finish cycle.
- R8: A request that stays high while the other cache is served is not lost. It is granted after that transfer, through idle, once no higher-priority request is pending. A transfer in progress is never pre-empted.
- R9: Back-to-back data-cache requests each complete in turn, and the controller never stalls. The instruction cache may wait indefinitely while this goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ic_req | input | 1 | Instruction-cache refill request |
| ic_addr | input | AW | Instruction-cache word address |
| ic_grant | output | 1 | Instruction cache owns the memory port |
| ic_done | output | 1 | One-cycle completion pulse for the instruction cache |
| ic_data | output | DW | Refill word, valid with `ic_done` |
| dc_req | input | 1 | Data-cache refill request |
| dc_addr | input | AW | Data-cache word address |
| dc_grant | output | 1 | Data cache owns the memory port |
| dc_done | output | 1 | One-cycle completion pulse for the data cache |
| dc_data | output | DW | Refill word, valid with `dc_done` |
| mem_req | output | 1 | Read request (valid) to memory |
| mem_addr | output | AW | Read address to memory |
| mem_rvalid | input | 1 | Memory returns read data |
| mem_rdata | input | DW | Read data from memory |

## Verification
The bench builds the arbiter with `AW=8` and `DW=16`. With these widths, each returned word can be computed from its address in the bench, and every address used stays distinct. Memory latency is swept over 0 to 3 wait cycles, including the case where the answer comes in the first request cycle. Each latency is combined with every arrival order of the two requests: alone, together, and one arriving while the other is in flight. A final run keeps the data cache requesting back to back, to show that the instruction cache is held off and then served.

// File: rtl/refill_arb_pkg.sv
package refill_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_IFETCH = 3'd1,
    ST_DFETCH = 3'd2,
    ST_IFIN   = 3'd3,
    ST_DFIN   = 3'd4
  } arb_state_t;

  localparam int NREQ   = 2;
  localparam int IDX_IC = 0;
  localparam int IDX_DC = 1;

endpackage

// File: rtl/refill_arb_fsm.sv
module refill_arb_fsm
  import refill_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ic_req,
  input  logic       dc_req,
  input  logic       mem_rvalid,
  output arb_state_t state_q,
  output logic       launch,
  output logic       pick_dc,
  output logic       land
);

  arb_state_t state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (dc_req)      state_d = ST_DFETCH;
        else if (ic_req) state_d = ST_IFETCH;
      end
      ST_IFETCH: if (mem_rvalid) state_d = ST_IFIN;
      ST_DFETCH: if (mem_rvalid) state_d = ST_DFIN;
      ST_IFIN:   state_d = ST_IDLE;
      ST_DFIN:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign launch  = (state_q == ST_IDLE) && (ic_req || dc_req);
  assign pick_dc = dc_req;
  assign land    = ((state_q == ST_IFETCH) || (state_q == ST_DFETCH)) && mem_rvalid;

  // R1: reset lands in idle
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> state_q == ST_IDLE);

  // R2: data cache wins from idle
  p_dc_first_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && dc_req) |=> state_q == ST_DFETCH);

  // R3: instruction fetch only with a lone instruction request
  p_ic_alone_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && ic_req && !dc_req) |=> state_q == ST_IFETCH);

  // R4: fetch waits for memory
  p_fetch_wait_r4: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IFETCH || state_q == ST_DFETCH) && !mem_rvalid) |=> $stable(state_q));

  // R6: finish always goes back to idle
  p_fin_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IFIN || state_q == ST_DFIN) |=> state_q == ST_IDLE);

endmodule

// File: rtl/refill_arb_route.sv
module refill_arb_route
  import refill_arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  arb_state_t               state_q,
  input  logic                     launch,
  input  logic                     pick_dc,
  input  logic                     land,
  input  logic [NREQ-1:0][AW-1:0]  req_addr,
  input  logic                     mem_rvalid,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  output logic [NREQ-1:0]          grant,
  output logic [NREQ-1:0]          done,
  output logic [DW-1:0]            rsp_data
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          fetching, finishing, owner_dc;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (launch) addr_q <= req_addr[pick_dc];
      if (land)   data_q <= mem_rdata;
    end
  end

  assign fetching  = (state_q == ST_IFETCH) || (state_q == ST_DFETCH);
  assign finishing = (state_q == ST_IFIN)   || (state_q == ST_DFIN);
  assign owner_dc  = (state_q == ST_DFETCH) || (state_q == ST_DFIN);

  assign mem_req  = fetching;
  assign mem_addr = addr_q;
  assign rsp_data = data_q;

  for (genvar g = 0; g < NREQ; g++) begin : g_port
    localparam logic IS_DC = (g == IDX_DC);
    assign grant[g] = (fetching || finishing) && (owner_dc == IS_DC);
    assign done[g]  = finishing && (owner_dc == IS_DC);

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      done[g] |=> !done[g]);

    // R7: grant held from fetch into finish
    p_grant_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (grant[g] && mem_req && mem_rvalid) |=> grant[g]);
  end

  // R1: quiet outputs after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (grant == '0) && (done == '0) && !mem_req);

  // R4: request and address held until data returns
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr));

  // R5: exactly one done after a return, carrying the returned word
  p_return_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid) |=> ($countones(done) == 1) && (rsp_data == $past(mem_rdata)));

  // R7: grants exclusive
  p_grant_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R6: no memory traffic straight after a finish
  p_idle_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (done != '0) |=> !mem_req && (grant == '0));

endmodule

// File: rtl/refill_arb.sv
module refill_arb
  import refill_arb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ic_req,
  input  logic [AW-1:0] ic_addr,
  output logic          ic_grant,
  output logic          ic_done,
  output logic [DW-1:0] ic_data,
  input  logic          dc_req,
  input  logic [AW-1:0] dc_addr,
  output logic          dc_grant,
  output logic          dc_done,
  output logic [DW-1:0] dc_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);

  arb_state_t              state_q;
  logic                    launch, pick_dc, land;
  logic [NREQ-1:0][AW-1:0] req_addr;
  logic [NREQ-1:0]         grant, done;
  logic [DW-1:0]           rsp_data;

  assign req_addr[IDX_IC] = ic_addr;
  assign req_addr[IDX_DC] = dc_addr;

  refill_arb_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ic_req     (ic_req),
    .dc_req     (dc_req),
    .mem_rvalid (mem_rvalid),
    .state_q    (state_q),
    .launch     (launch),
    .pick_dc    (pick_dc),
    .land       (land)
  );

  refill_arb_route #(.AW(AW), .DW(DW)) u_route (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .launch     (launch),
    .pick_dc    (pick_dc),
    .land       (land),
    .req_addr   (req_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .grant      (grant),
    .done       (done),
    .rsp_data   (rsp_data)
  );

  assign ic_grant = grant[IDX_IC];
  assign dc_grant = grant[IDX_DC];
  assign ic_done  = done[IDX_IC];
  assign dc_done  = done[IDX_DC];
  assign ic_data  = rsp_data;
  assign dc_data  = rsp_data;

endmodule

// File: tb/sim_refill_arb.sv
`timescale 1ns/1ps
module sim_refill_arb;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ic_req = 1'b0, dc_req = 1'b0;
  logic [AW-1:0] ic_addr = '0, dc_addr = '0;
  logic          ic_grant, dc_grant, ic_done, dc_done, mem_req;
  logic [DW-1:0] ic_data, dc_data;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int errors = 0, checks = 0;
  int ic_cnt = 0, dc_cnt = 0;
  int first_src = 0;          // 0 none, 1 ic, 2 dc
  int lat_sel = 0;
  bit dc_auto = 0;
  logic [AW-1:0] dc_next = '0;

  always #4 clk = ~clk;       // 125 MHz

  refill_arb #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .ic_req(ic_req), .ic_addr(ic_addr), .ic_grant(ic_grant), .ic_done(ic_done), .ic_data(ic_data),
    .dc_req(dc_req), .dc_addr(dc_addr), .dc_grant(dc_grant), .dc_done(dc_done), .dc_data(dc_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 8'hA5, a + 8'd3};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model and completion monitor
  bit            busy = 0, after_done = 0;
  int            wait_left = 0;
  logic [AW-1:0] held_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (after_done) begin
        chk(!mem_req && !ic_grant && !dc_grant, "R6 idle gap", {mem_req, ic_grant, dc_grant}, 0);
        chk(!ic_done && !dc_done, "R5 single pulse", {ic_done, dc_done}, 0);
      end
      after_done = ic_done || dc_done;
      if (ic_done) begin
        chk(ic_data == mem_word(ic_addr), "R5 ic data", ic_data, mem_word(ic_addr));
        chk(!dc_done && ic_grant && !dc_grant, "R7 ic owner", {dc_done, ic_grant, dc_grant}, 3'b010);
        ic_cnt++;
        if (first_src == 0) first_src = 1;
        ic_req = 1'b0;
      end
      if (dc_done) begin
        chk(dc_data == mem_word(dc_addr), "R5 dc data", dc_data, mem_word(dc_addr));
        chk(!ic_done && dc_grant && !ic_grant, "R7 dc owner", {ic_done, dc_grant, ic_grant}, 3'b010);
        dc_cnt++;
        if (first_src == 0) first_src = 2;
        if (dc_auto) begin
          dc_next = dc_next + 1;
          dc_addr = dc_next;
        end else dc_req = 1'b0;
      end
      if (mem_req) begin
        if (!busy) begin
          busy = 1; wait_left = lat_sel; held_addr = mem_addr;
        end
        if (wait_left == 0) begin
          chk(mem_addr == held_addr, "R4 addr held", mem_addr, held_addr);
          chk(mem_addr == (dc_grant ? dc_addr : ic_addr), "R2 R3 addr route", mem_addr,
              dc_grant ? dc_addr : ic_addr);
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(mem_addr);
        end else begin
          wait_left--;
          mem_rvalid = 1'b0;
        end
      end else begin
        busy = 0; mem_rvalid = 1'b0;
      end
    end
  end

  task automatic drive_tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_counts(input int ic_t, input int dc_t, input string req);
    for (int n = 0; n < 200; n++) begin
      if (ic_cnt >= ic_t && dc_cnt >= dc_t) break;
      @(posedge clk);
    end
    chk(ic_cnt >= ic_t && dc_cnt >= dc_t, req, {ic_cnt, dc_cnt}, {ic_t, dc_t});
    repeat (3) @(posedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    // R1: requests asserted under reset have no effect
    ic_req = 1'b1; dc_req = 1'b1; ic_addr = 8'h11; dc_addr = 8'h22;
    repeat (3) begin
      @(negedge clk);
      chk(!ic_grant && !dc_grant && !mem_req && !ic_done && !dc_done, "R1 reset quiet",
          {ic_grant, dc_grant, mem_req, ic_done, dc_done}, 0);
    end
    ic_req = 1'b0; dc_req = 1'b0;
    drive_tick(); rst = 1'b0;
    @(negedge clk);
    chk(!ic_grant && !dc_grant && !mem_req, "R1 after reset", {ic_grant, dc_grant, mem_req}, 0);

    base = 0;
    for (int lat = 0; lat < 4; lat++) begin
      lat_sel = lat;

      // instruction cache alone
      drive_tick(); ic_addr = 8'h10 + 8'(base); ic_req = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(ic_grant && mem_req && mem_addr == ic_addr, "R3 lone ic grant", {ic_grant, mem_req, mem_addr}, {2'b11, ic_addr});
      wait_counts(ic_cnt + 1, dc_cnt, "R3 ic completes");

      // data cache alone
      drive_tick(); dc_addr = 8'h80 + 8'(base); dc_req = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(dc_grant && mem_req && mem_addr == dc_addr, "R2 lone dc grant", {dc_grant, mem_req, mem_addr}, {2'b11, dc_addr});
      wait_counts(ic_cnt, dc_cnt + 1, "R2 dc completes");

      // both together: data first, instruction kept pending
      first_src = 0;
      drive_tick(); ic_addr = 8'h30 + 8'(base); dc_addr = 8'hA0 + 8'(base);
      ic_req = 1'b1; dc_req = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(dc_grant && !ic_grant, "R2 R3 dc beats ic", {dc_grant, ic_grant}, 2'b10);
      wait_counts(ic_cnt + 1, dc_cnt + 1, "R8 pending ic served");
      chk(first_src == 2, "R2 order dc first", first_src, 2);

      // instruction in flight, data arrives: no pre-emption
      first_src = 0;
      drive_tick(); ic_addr = 8'h50 + 8'(base); ic_req = 1'b1;
      drive_tick(); dc_addr = 8'hC0 + 8'(base); dc_req = 1'b1;
      @(negedge clk);
      chk(ic_grant && !dc_grant, "R8 no preempt", {ic_grant, dc_grant}, 2'b10);
      wait_counts(ic_cnt + 1, dc_cnt + 1, "R8 late dc served");
      chk(first_src == 1, "R8 order ic first", first_src, 1);

      // no request: bus quiet
      repeat (4) begin
        @(negedge clk);
        chk(!mem_req && !ic_grant && !dc_grant, "R6 quiet idle", {mem_req, ic_grant, dc_grant}, 0);
      end
      base = base + 1;
    end

    // R9: back-to-back data requests starve the instruction cache without deadlock
    lat_sel = 1;
    begin
      int ic0, dc0;
      ic0 = ic_cnt; dc0 = dc_cnt;
      drive_tick();
      dc_next = 8'hE0; dc_addr = dc_next; ic_addr = 8'h70;
      dc_auto = 1; dc_req = 1'b1; ic_req = 1'b1;
      wait_counts(ic0, dc0 + 6, "R9 dc stream progresses");
      chk(ic_cnt == ic0, "R9 ic held off", ic_cnt, ic0);
      drive_tick(); dc_auto = 0;
      wait_counts(ic0 + 1, dc0 + 7, "R9 R8 ic served after stream");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule